// File: doc/BRIEF.md
# Edge-Armed Input Debouncer with Double-Edge Events

This block filters noisy input pins one channel per pin. A channel sleeps until an edge trigger (the cause bit of an external edge detector) arms it. It then samples the synchronized pin level once per tick from a shared millisecond strobe. A new level is accepted only after a run of consecutive samples that disagree with the held state. Any agreeing sample reloads the run length. When a level is accepted, the channel updates its filtered state and returns to sleep. It may raise an event pulse, and it always asks the external polarity register to flip, so that the opposite edge sets the cause bit next time.

Each pin carries three configuration bits: filtering enable, double-edge mode and active-low. With filtering off, a trigger is passed on at once as an event, and in double-edge mode the polarity flip is requested on the same cycle. An initialize strobe loads the filtered state from the pin and asks the polarity register to take the current level, so that the present level reads as inactive. A read value per pin presents the filtered or raw level, with active-low applied where the mode calls for it.

Top module: `edge_debouncer`

## Requirements
- R1: After reset every output pulse, every filtered state and every read value is 0, and each run counter holds the low-to-high run length.
- R2: The raw pin passes through two flip-flops, so a change on raw_i reaches the read value two clock edges later. Samples are taken only on a cycle with tick_i high while the channel's run is active.
- R3: A low-to-high change is accepted after RISE_RUN consecutive disagreeing samples (default 2), and a high-to-low change after FALL_RUN (default 2). A sample equal to the filtered state reloads the count to the run length for that state. A glitch shorter than the run length leaves the state unchanged.
- R4: On acceptance the filtered state takes the sampled level, the count reloads for the new state, the run stops and pol_flip_o pulses for one cycle.
- R5: On acceptance event_o pulses if the new level is 1 with act_low_i = 0, or if it is 0 with act_low_i = 1. In double-edge mode (dbl_edge_i = 1) it pulses on every acceptance.
- R6: The init_i strobe has priority over all else. The filtered state takes the synchronized level, the run stops, the count loads for that level, and pol_load_o pulses with pol_level_o equal to that level.
- R7: A trigger while a run is active pulses cause_ack_o and neither restarts the run nor reloads its count.
- R8: A trigger with filtering on and no run active starts a run and produces no output pulse.
- R9: With filtering off and double-edge on, every trigger gives event_o and pol_flip_o on the next cycle.
- R10: With filtering and double-edge both off, every trigger gives event_o alone on the next cycle.
- R11: With filtering on, the read value is the filtered state XOR act_low_i. With filtering off and double-edge on, it is the synchronized level XOR act_low_i. Otherwise it is the synchronized level.
- R12: Clearing filter_en_i abandons an active run. The filtered state then stays as it is until a new trigger arms the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle sample strobe (millisecond) |
| raw_i | input | NPINS | Raw pin levels |
| trig_i | input | NPINS | Edge trigger per pin |
| init_i | input | NPINS | Initialize strobe per pin |
| filter_en_i | input | NPINS | Filtering enable per pin |
| dbl_edge_i | input | NPINS | Double-edge mode per pin |
| act_low_i | input | NPINS | Active-low flag per pin |
| filt_state_o | output | NPINS | Filtered state per pin |
| read_val_o | output | NPINS | Read value per pin |
| event_o | output | NPINS | Event pulse |
| pol_flip_o | output | NPINS | Polarity flip request pulse |
| pol_load_o | output | NPINS | Polarity load request pulse |
| pol_level_o | output | NPINS | Level to load into polarity, valid with pol_load_o |
| cause_ack_o | output | NPINS | Cause acknowledge pulse |

## Verification
A trigger can arrive on the same cycle as the tick whose sample completes a run. That cycle must then produce the acknowledge together with the acceptance pulses (state change, flip, and possibly an event). The random phase drives triggers densely while ticks recur every few cycles, so such collisions occur many times. A cycle-level reference model in the bench predicts cause_ack_o, event_o and pol_flip_o for those cycles, and every output is compared against it on every cycle.

// File: rtl/edb_pkg.sv
package edb_pkg;

  typedef struct packed {
    logic filter_en;
    logic dbl_edge;
    logic act_low;
  } edb_cfg_t;

  typedef struct packed {
    logic evt;
    logic flip;
    logic ack;
    logic load;
    logic load_lvl;
  } edb_pulse_t;

  function automatic int unsigned edb_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edb_rst_sync.sv
module edb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/edb_sync.sv
module edb_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/edb_channel.sv
module edb_channel
  import edb_pkg::*;
#(
  parameter int unsigned RISE_RUN = 2,
  parameter int unsigned FALL_RUN = 2,
  parameter int unsigned CW       = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       lvl,
  input  logic       trig,
  input  logic       init,
  input  edb_cfg_t   cfg,
  output logic       filt_state,
  output logic       read_val,
  output edb_pulse_t pulses
);
  localparam logic [CW-1:0] RISE_LD = CW'(RISE_RUN);
  localparam logic [CW-1:0] FALL_LD = CW'(FALL_RUN);
  localparam logic [CW-1:0] ONE     = CW'(1);

  function automatic logic [CW-1:0] run_len(input logic held);
    return held ? FALL_LD : RISE_LD;
  endfunction

  logic          run_q, run_d;
  logic          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  edb_pulse_t    pls_q, pls_d;
  logic          upd_en;
  logic          sample_now;
  logic          disagree;
  logic          finish;

  assign sample_now = cfg.filter_en && run_q && tick && !(trig && !run_q);
  assign disagree   = (lvl != st_q);
  assign finish     = sample_now && disagree && (cnt_q == ONE);

  assign upd_en = init || trig || tick || (run_q && !cfg.filter_en);

  always_comb begin
    run_d = run_q;
    st_d  = st_q;
    cnt_d = cnt_q;
    pls_d = '0;
    if (init) begin
      st_d           = lvl;
      cnt_d          = run_len(lvl);
      run_d          = 1'b0;
      pls_d.load     = 1'b1;
      pls_d.load_lvl = lvl;
    end else if (!cfg.filter_en) begin
      run_d = 1'b0;
      if (trig) begin
        pls_d.evt  = 1'b1;
        pls_d.flip = cfg.dbl_edge;
      end
    end else begin
      if (trig && run_q) begin
        pls_d.ack = 1'b1;
      end
      if (trig && !run_q) begin
        run_d = 1'b1;
        cnt_d = run_len(st_q);
      end else if (sample_now) begin
        if (!disagree) begin
          cnt_d = run_len(st_q);
        end else if (finish) begin
          st_d       = lvl;
          cnt_d      = run_len(lvl);
          run_d      = 1'b0;
          pls_d.flip = 1'b1;
          pls_d.evt  = cfg.dbl_edge || (lvl ^ cfg.act_low);
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      st_q  <= 1'b0;
      cnt_q <= RISE_LD;
    end else if (upd_en) begin
      run_q <= run_d;
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pls_q <= '0;
    end else begin
      pls_q <= pls_d;
    end
  end

  always_comb begin
    if (cfg.filter_en) begin
      read_val = st_q ^ cfg.act_low;
    end else if (cfg.dbl_edge) begin
      read_val = lvl ^ cfg.act_low;
    end else begin
      read_val = lvl;
    end
  end

  assign filt_state = st_q;
  assign pulses     = pls_q;
endmodule

// File: rtl/edge_debouncer.sv
module edge_debouncer
  import edb_pkg::*;
#(
  parameter int unsigned NPINS    = 4,
  parameter int unsigned RISE_RUN = 2,
  parameter int unsigned FALL_RUN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [NPINS-1:0] raw_i,
  input  logic [NPINS-1:0] trig_i,
  input  logic [NPINS-1:0] init_i,
  input  logic [NPINS-1:0] filter_en_i,
  input  logic [NPINS-1:0] dbl_edge_i,
  input  logic [NPINS-1:0] act_low_i,
  output logic [NPINS-1:0] filt_state_o,
  output logic [NPINS-1:0] read_val_o,
  output logic [NPINS-1:0] event_o,
  output logic [NPINS-1:0] pol_flip_o,
  output logic [NPINS-1:0] pol_load_o,
  output logic [NPINS-1:0] pol_level_o,
  output logic [NPINS-1:0] cause_ack_o
);
  localparam int unsigned MAX_RUN = edb_max(RISE_RUN, FALL_RUN);
  localparam int unsigned CW      = $clog2(MAX_RUN + 1);

  logic             rst_n_int;
  logic [NPINS-1:0] lvl_sync;

  edb_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  edb_sync #(.WIDTH(NPINS)) u_lvl_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   (raw_i),
    .dout  (lvl_sync)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    edb_cfg_t   cfg;
    edb_pulse_t pls;

    assign cfg.filter_en = filter_en_i[p];
    assign cfg.dbl_edge  = dbl_edge_i[p];
    assign cfg.act_low   = act_low_i[p];

    edb_channel #(
      .RISE_RUN (RISE_RUN),
      .FALL_RUN (FALL_RUN),
      .CW       (CW)
    ) u_chan (
      .clk        (clk),
      .rst_n      (rst_n_int),
      .tick       (tick_i),
      .lvl        (lvl_sync[p]),
      .trig       (trig_i[p]),
      .init       (init_i[p]),
      .cfg        (cfg),
      .filt_state (filt_state_o[p]),
      .read_val   (read_val_o[p]),
      .pulses     (pls)
    );

    assign event_o[p]     = pls.evt;
    assign pol_flip_o[p]  = pls.flip;
    assign pol_load_o[p]  = pls.load;
    assign pol_level_o[p] = pls.load_lvl;
    assign cause_ack_o[p] = pls.ack;
  end
endmodule

// File: rtl/edb_checker.sv
module edb_checker #(
  parameter int unsigned NPINS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] trig_i,
  input logic [NPINS-1:0] init_i,
  input logic [NPINS-1:0] filter_en_i,
  input logic [NPINS-1:0] dbl_edge_i,
  input logic [NPINS-1:0] act_low_i,
  input logic [NPINS-1:0] filt_state_o,
  input logic [NPINS-1:0] event_o,
  input logic [NPINS-1:0] pol_flip_o,
  input logic [NPINS-1:0] pol_load_o,
  input logic [NPINS-1:0] pol_level_o,
  input logic [NPINS-1:0] cause_ack_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_chk
    // R4
    state_change_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((filt_state_o[p] != $past(filt_state_o[p])) && !$past(init_i[p])) |-> pol_flip_o[p]);

    // R6
    load_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pol_load_o[p] |-> (pol_level_o[p] == filt_state_o[p]));

    // R7
    ack_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cause_ack_o[p] |-> $past(trig_i[p] && filter_en_i[p]));

    // R9
    flip_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pol_flip_o[p] |-> $past(filter_en_i[p] || (trig_i[p] && dbl_edge_i[p])));

    // R5
    event_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (event_o[p] && $past(filter_en_i[p] && !dbl_edge_i[p] && !init_i[p]))
        |-> (filt_state_o[p] != $past(act_low_i[p])));
  end
endmodule

bind edge_debouncer edb_checker #(.NPINS(NPINS)) u_edb_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .trig_i       (trig_i),
  .init_i       (init_i),
  .filter_en_i  (filter_en_i),
  .dbl_edge_i   (dbl_edge_i),
  .act_low_i    (act_low_i),
  .filt_state_o (filt_state_o),
  .event_o      (event_o),
  .pol_flip_o   (pol_flip_o),
  .pol_load_o   (pol_load_o),
  .pol_level_o  (pol_level_o),
  .cause_ack_o  (cause_ack_o)
);

// File: tb/test_edge_debouncer.sv
`timescale 1ns/1ps
module test_edge_debouncer;
  localparam int NP    = 4;
  localparam int RISE  = 2;
  localparam int FALL  = 3;
  localparam int TPER  = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick_i;
  logic [NP-1:0] raw_i, trig_i, init_i, filter_en_i, dbl_edge_i, act_low_i;
  logic [NP-1:0] filt_state_o, read_val_o, event_o, pol_flip_o;
  logic [NP-1:0] pol_load_o, pol_level_o, cause_ack_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  bit checking = 0;

  always #5 clk = ~clk;

  edge_debouncer #(.NPINS(NP), .RISE_RUN(RISE), .FALL_RUN(FALL)) i_edge_debouncer (
    .clk, .rst_n, .tick_i, .raw_i, .trig_i, .init_i, .filter_en_i, .dbl_edge_i,
    .act_low_i, .filt_state_o, .read_val_o, .event_o, .pol_flip_o, .pol_load_o,
    .pol_level_o, .cause_ack_o
  );

  // reference model state
  logic [NP-1:0] m_s1, m_s2, m_run, m_st, m_ev, m_fl, m_ak, m_ld, m_lv;
  int            m_cnt [NP];
  logic          m_r1, m_r2;

  function automatic int run_len(input logic held);
    return held ? FALL : RISE;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0;
      m_s1 = '0; m_s2 = '0; m_run = '0; m_st = '0;
      m_ev = '0; m_fl = '0; m_ak = '0; m_ld = '0; m_lv = '0;
      for (int p = 0; p < NP; p++) m_cnt[p] = RISE;
    end else begin
      if (!m_r2) begin
        m_s1 = '0; m_s2 = '0; m_run = '0; m_st = '0;
        m_ev = '0; m_fl = '0; m_ak = '0; m_ld = '0; m_lv = '0;
        for (int p = 0; p < NP; p++) m_cnt[p] = RISE;
      end else begin
        for (int p = 0; p < NP; p++) begin
          logic rs;
          rs = m_s2[p];
          m_ev[p] = 0; m_fl[p] = 0; m_ak[p] = 0; m_ld[p] = 0; m_lv[p] = 0;
          if (init_i[p]) begin
            m_st[p] = rs; m_cnt[p] = run_len(rs); m_run[p] = 0;
            m_ld[p] = 1; m_lv[p] = rs;
          end else if (!filter_en_i[p]) begin
            m_run[p] = 0;
            if (trig_i[p]) begin m_ev[p] = 1; m_fl[p] = dbl_edge_i[p]; end
          end else if (trig_i[p] && m_run[p]) begin
            m_ak[p] = 1;
            if (tick_i) begin
              if (rs == m_st[p]) m_cnt[p] = run_len(m_st[p]);
              else if (m_cnt[p] == 1) begin
                m_st[p] = rs; m_cnt[p] = run_len(rs); m_run[p] = 0; m_fl[p] = 1;
                m_ev[p] = dbl_edge_i[p] | (rs ^ act_low_i[p]);
              end else m_cnt[p] = m_cnt[p] - 1;
            end
          end else if (trig_i[p]) begin
            m_run[p] = 1; m_cnt[p] = run_len(m_st[p]);
          end else if (tick_i && m_run[p]) begin
            if (rs == m_st[p]) m_cnt[p] = run_len(m_st[p]);
            else if (m_cnt[p] == 1) begin
              m_st[p] = rs; m_cnt[p] = run_len(rs); m_run[p] = 0; m_fl[p] = 1;
              m_ev[p] = dbl_edge_i[p] | (rs ^ act_low_i[p]);
            end else m_cnt[p] = m_cnt[p] - 1;
          end
        end
        m_s2 = m_s1;
        m_s1 = raw_i;
      end
      m_r2 = m_r1;
      m_r1 = 1;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag, input int pin);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s pin %0d: actual=%b expected=%b", tag, pin, act, exp);
    end
  endtask

  function automatic logic exp_read(input int p);
    if (filter_en_i[p]) return m_st[p] ^ act_low_i[p];
    if (dbl_edge_i[p])  return m_s2[p] ^ act_low_i[p];
    return m_s2[p];
  endfunction

  // continuous comparison against the model, away from the clock edge
  always @(negedge clk) begin
    #3;
    if (checking && !done) begin
      for (int p = 0; p < NP; p++) begin
        chk(filt_state_o[p], m_st[p], "R3 filtered state", p);
        chk(event_o[p],      m_ev[p], "R5 event", p);
        chk(pol_flip_o[p],   m_fl[p], "R4 polarity flip", p);
        chk(cause_ack_o[p],  m_ak[p], "R7 cause ack", p);
        chk(pol_load_o[p],   m_ld[p], "R6 polarity load", p);
        chk(pol_level_o[p],  m_lv[p], "R6 load level", p);
        chk(read_val_o[p],   exp_read(p), "R11 read value", p);
      end
    end
  end

  // tick source
  int tick_cnt = 0;
  always @(negedge clk) begin
    tick_cnt = (tick_cnt == TPER - 1) ? 0 : tick_cnt + 1;
    tick_i  <= (tick_cnt == TPER - 1);
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d0b_5eed));
    rst_n = 0; tick_i = 0;
    raw_i = '0; trig_i = '0; init_i = '0;
    filter_en_i = '0; dbl_edge_i = '0; act_low_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    checking = 1;
    repeat (4) @(negedge clk);
    #3;
    // R1: reset state
    for (int p = 0; p < NP; p++) begin
      chk(filt_state_o[p], 1'b0, "R1 reset state", p);
      chk(event_o[p] | pol_flip_o[p] | pol_load_o[p] | cause_ack_o[p], 1'b0, "R1 reset pulses", p);
    end

    @(negedge clk);
    filter_en_i = 4'b1001;
    init_i = '1;
    @(negedge clk);
    init_i = '0;

    // R3: low-to-high accepted on pin 0
    raw_i[0] = 1;
    repeat (3) @(negedge clk);
    trig_i[0] = 1;
    @(negedge clk);
    trig_i[0] = 0;
    repeat (40) @(negedge clk);
    #3 chk(filt_state_o[0], 1'b1, "R3 rise accepted", 0);

    // R3: short glitch rejected
    @(negedge clk);
    raw_i[0] = 0; trig_i[0] = 1;
    @(negedge clk);
    trig_i[0] = 0;
    @(negedge clk);
    raw_i[0] = 1;
    repeat (40) @(negedge clk);
    #3 chk(filt_state_o[0], 1'b1, "R3 glitch rejected", 0);

    // R2: two-stage synchronizer latency on pin 2 (filter off)
    @(negedge clk);
    raw_i[2] = 1;
    #3 chk(read_val_o[2], 1'b0, "R2 latency edge 0", 2);
    @(negedge clk);
    #3 chk(read_val_o[2], 1'b0, "R2 latency edge 1", 2);
    @(negedge clk);
    #3 chk(read_val_o[2], 1'b1, "R2 latency edge 2", 2);

    // R10: plain trigger forwarding
    @(negedge clk);
    trig_i[2] = 1;
    @(negedge clk);
    trig_i[2] = 0;
    #3;
    chk(event_o[2], 1'b1, "R10 event", 2);
    chk(pol_flip_o[2], 1'b0, "R10 no flip", 2);

    // R9: double-edge without filtering
    @(negedge clk);
    dbl_edge_i[2] = 1; trig_i[2] = 1;
    @(negedge clk);
    trig_i[2] = 0;
    #3;
    chk(event_o[2], 1'b1, "R9 event", 2);
    chk(pol_flip_o[2], 1'b1, "R9 flip", 2);

    // R8: arming a run gives no pulse
    @(negedge clk);
    raw_i[3] = 1;
    repeat (3) @(negedge clk);
    trig_i[3] = 1;
    @(negedge clk);
    trig_i[3] = 0;
    #3;
    chk(event_o[3] | pol_flip_o[3] | cause_ack_o[3], 1'b0, "R8 silent arm", 3);

    // R12: clearing the enable abandons the run
    @(negedge clk);
    filter_en_i[3] = 0;
    repeat (30) @(negedge clk);
    filter_en_i[3] = 1;
    repeat (30) @(negedge clk);
    #3;
    chk(filt_state_o[3], 1'b0, "R12 run abandoned", 3);
    chk(read_val_o[3], 1'b0, "R11 filtered read", 3);
    @(negedge clk);
    act_low_i[3] = 1;
    #3 chk(read_val_o[3], 1'b1, "R11 inverted read", 3);

    // random phase, model-checked
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        if (($urandom % 16) == 0)  raw_i[p] = ~raw_i[p];
        trig_i[p] = (($urandom % 6) == 0);
        init_i[p] = (($urandom % 150) == 0);
        if (($urandom % 300) == 0) filter_en_i[p] = ~filter_en_i[p];
        if (($urandom % 300) == 0) dbl_edge_i[p]  = ~dbl_edge_i[p];
        if (($urandom % 300) == 0) act_low_i[p]   = ~act_low_i[p];
      end
    end
    @(negedge clk);
    trig_i = '0; init_i = '0;
    repeat (3) @(negedge clk);
    #4;
    done = 1;
    summary();
    $finish;
  end
endmodule